// File: doc/BRIEF.md
# AC-link Output Frame Assembler

This block builds each outgoing frame of the AC-link serial audio and modem link and shifts it out one bit per bit clock. A frame is 256 bit times: a 16-bit tag followed by twelve 20-bit slots, sent MSB first. The frame-sync output is high for the 16 tag bit times. The block takes one PCM word for each of six playback channels, a 16-bit modem DAC word, a channel-mode setting, and codec register-write events. It decides which slots carry data and which are zero-stuffed, and it sets a valid flag in the tag for each slot that carries data.

All data inputs and the channel mode are sampled once per frame, in the last bit time before the frame starts. A register write is latched when it arrives and goes out in the next frame as an address slot and a data slot. A write to the GPIO control register (address 54h for the primary codec, D4h for the secondary) also loads a shadow register. Slot 12 carries that shadow register in every later frame until a link reset invalidates it.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame is 256 bit clocks long and `sync_o` is high for its first 16 bit times. During reset `sync_o` and `sdata_o` are 0, and the first frame starts on the first clock edge after `rst_ni` is released. Bits are sent MSB first: tag bit 15 first, then slots 1 to 12, each from bit 19 down to bit 0.
- R2: Tag bit 15 is always 1. Tag bits 14 down to 3 are the valid flags of slots 1 to 12, in that order, and tag bit 2 is 0. In a frame that carries a register write, tag bits 1:0 are {0, address bit 7}; otherwise they are 00. A slot whose valid flag is 0 is all zeros.
- R3: Slots 3 and 4 carry `pcm_left_i` and `pcm_right_i` and are always valid. Slot 5 carries {`modem_dac_i`, 4'b0000} and is always valid.
- R4: When `chan_mode_i` is 00 (two channels) or 11 (treated as two channels), slots 6 to 9 are zero and flagged invalid.
- R5: When `chan_mode_i` is 01 (four channels), slots 7 and 8 carry `pcm_rear_left_i` and `pcm_rear_right_i` and are valid, while slots 6 and 9 are zero and flagged invalid.
- R6: When `chan_mode_i` is 10 (six channels), slots 6, 7, 8 and 9 carry the center, rear-left, rear-right and subwoofer words and are valid. Slots 10 and 11 are zero and flagged invalid in every mode.
- R7: A pulse on `reg_wr_i` puts slot 1 = {0, `reg_addr_i`[6:0], 12'h000} and slot 2 = {`reg_wdata_i`, 4'h0}, both valid, into the next frame. A pulse in the last bit time of a frame goes into the frame that starts on the next clock. If several writes arrive before a frame starts, only the last one is sent. Frames that carry no write have slots 1 and 2 zero and invalid.
- R8: After reset, slot 12 is invalid and zero. A write to address 54h or D4h makes slot 12 = {data, 4'h0} and valid, starting in the same frame that carries the write in slots 1 and 2. Slot 12 then repeats the last GPIO value in every frame. Writes to other addresses leave slot 12 unchanged.
- R9: A pulse on `link_reset_i` invalidates slot 12 and discards any write that has not yet been sent, including a write in the same cycle. The frame already being shifted out is not changed. Slot 12 stays invalid until the next GPIO write.
- R10: The data inputs and `chan_mode_i` only affect the frame that starts after they are sampled. Changes during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset (bus or cold reset) |
| link_reset_i | input | 1 | Synchronous warm link reset pulse |
| chan_mode_i | input | 2 | 00 two, 01 four, 10 six channels, 11 two |
| pcm_left_i | input | 20 | Front left sample |
| pcm_right_i | input | 20 | Front right sample |
| pcm_center_i | input | 20 | Front center sample |
| pcm_rear_left_i | input | 20 | Rear left sample |
| pcm_rear_right_i | input | 20 | Rear right sample |
| pcm_sub_i | input | 20 | Subwoofer sample |
| modem_dac_i | input | 16 | Modem DAC word |
| reg_wr_i | input | 1 | Codec register write strobe |
| reg_addr_i | input | 8 | Register address, bit 7 selects the secondary codec |
| reg_wdata_i | input | 16 | Register write data |
| sync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial frame data |

## Verification
Two pairs of functions can fall in the same cycle. The first is a register write arriving in bit time 255, the same cycle in which the next frame is loaded. The bench provokes it by pulsing the write at the sample point where a capture completes, and it requires the write to appear in the very next frame. The second is a GPIO write arriving in the same cycle as `link_reset_i`. The bench drives both in one mid-frame cycle and requires that the next frame has slots 1, 2 and 12 all invalid and zero.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int PCM_W     = 20;
  localparam int DAC_W     = 16;
  localparam int GPIO_W    = 16;
  localparam int ADDR_W    = 8;
  localparam int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS;

  localparam logic [ADDR_W-1:0] GPIO_ADDR_PRI = 8'h54;
  localparam logic [ADDR_W-1:0] GPIO_ADDR_SEC = 8'hD4;

  typedef enum logic [1:0] {
    MODE_2CH  = 2'b00,
    MODE_4CH  = 2'b01,
    MODE_6CH  = 2'b10,
    MODE_RSVD = 2'b11
  } chmode_e;
endpackage

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic frame_start_o,
  output logic sync_o
);
  localparam int FRAME_W = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt_q;

  // reset parks on the last bit so the first edge out of reset opens a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign frame_start_o = (cnt_q == LAST);
  assign sync_o        = (cnt_q < CNT_W'(TAG_W));

  assert_sync_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> $rose(sync_o));
  assert_sync_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> ($past(cnt_q) == CNT_W'(TAG_W - 1)));
endmodule

// File: rtl/aclink_cmd_tracker.sv
module aclink_cmd_tracker #(
  parameter int ADDR_W = 8,
  parameter int GPIO_W = 16,
  parameter logic [ADDR_W-1:0] GPIO_PRI = 8'h54,
  parameter logic [ADDR_W-1:0] GPIO_SEC = 8'hD4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              link_reset_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [GPIO_W-1:0] wr_data_i,
  // view of the frame about to be loaded
  output logic              cmd_vld_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [GPIO_W-1:0] cmd_data_o,
  output logic              gpio_vld_o,
  output logic [GPIO_W-1:0] gpio_data_o
);
  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [GPIO_W-1:0] pend_data_q;
  logic              gpio_vld_q;
  logic [GPIO_W-1:0] gpio_q;
  logic              gpio_hit;

  // a write in the boundary cycle bypasses the pending register
  assign cmd_addr_o  = wr_i ? wr_addr_i : pend_addr_q;
  assign cmd_data_o  = wr_i ? wr_data_i : pend_data_q;
  assign cmd_vld_o   = !link_reset_i && (wr_i || pend_vld_q);
  assign gpio_hit    = cmd_vld_o && ((cmd_addr_o == GPIO_PRI) || (cmd_addr_o == GPIO_SEC));
  assign gpio_vld_o  = !link_reset_i && (gpio_hit || gpio_vld_q);
  assign gpio_data_o = gpio_hit ? cmd_data_o : gpio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      gpio_vld_q  <= 1'b0;
      gpio_q      <= '0;
    end else if (link_reset_i) begin
      pend_vld_q <= 1'b0;
      gpio_vld_q <= 1'b0;
    end else if (frame_start_i) begin
      pend_vld_q <= 1'b0;
      gpio_vld_q <= gpio_vld_o;
      if (gpio_hit) gpio_q <= cmd_data_o;
    end else if (wr_i) begin
      pend_vld_q  <= 1'b1;
      pend_addr_q <= wr_addr_i;
      pend_data_q <= wr_data_i;
    end
  end

  assert_gpio_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gpio_vld_q) |-> $past(link_reset_i));
  assert_gpio_frame_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gpio_q) |-> $past(frame_start_i));
  assert_pend_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !pend_vld_q);
  assert_link_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_reset_i |=> (!gpio_vld_q && !pend_vld_q));
endmodule

// File: rtl/aclink_slot_mux.sv
module aclink_slot_mux
  import aclink_tx_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int PCM_W     = 20,
  parameter int DAC_W     = 16,
  parameter int GPIO_W    = 16,
  parameter int ADDR_W    = 8
) (
  input  chmode_e                                 mode_i,
  input  logic [PCM_W-1:0]                        pcm_l_i,
  input  logic [PCM_W-1:0]                        pcm_r_i,
  input  logic [PCM_W-1:0]                        pcm_c_i,
  input  logic [PCM_W-1:0]                        pcm_rl_i,
  input  logic [PCM_W-1:0]                        pcm_rr_i,
  input  logic [PCM_W-1:0]                        pcm_sw_i,
  input  logic [DAC_W-1:0]                        dac_i,
  input  logic                                    cmd_vld_i,
  input  logic [ADDR_W-1:0]                       cmd_addr_i,
  input  logic [GPIO_W-1:0]                       cmd_data_i,
  input  logic                                    gpio_vld_i,
  input  logic [GPIO_W-1:0]                       gpio_data_i,
  output logic [TAG_W+SLOT_W*NUM_SLOTS-1:0]       frame_o
);
  localparam int FRAME_W  = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int TAG_LO_W = TAG_W - 1 - NUM_SLOTS;

  logic [SLOT_W-1:0]    slot_data [1:NUM_SLOTS];
  logic [NUM_SLOTS:1]   slot_vld;
  logic                 six_ch, four_up;

  assign six_ch  = (mode_i == MODE_6CH);
  assign four_up = six_ch || (mode_i == MODE_4CH);

  always_comb begin
    for (int s = 1; s <= NUM_SLOTS; s++) slot_data[s] = '0;
    slot_vld      = '0;
    slot_vld[1]   = cmd_vld_i;
    slot_data[1]  = {1'b0, cmd_addr_i[ADDR_W-2:0], {(SLOT_W-ADDR_W){1'b0}}};
    slot_vld[2]   = cmd_vld_i;
    slot_data[2]  = {cmd_data_i, {(SLOT_W-GPIO_W){1'b0}}};
    slot_vld[3]   = 1'b1;
    slot_data[3]  = pcm_l_i;
    slot_vld[4]   = 1'b1;
    slot_data[4]  = pcm_r_i;
    slot_vld[5]   = 1'b1;
    slot_data[5]  = {dac_i, {(SLOT_W-DAC_W){1'b0}}};
    slot_vld[6]   = six_ch;
    slot_data[6]  = pcm_c_i;
    slot_vld[7]   = four_up;
    slot_data[7]  = pcm_rl_i;
    slot_vld[8]   = four_up;
    slot_data[8]  = pcm_rr_i;
    slot_vld[9]   = six_ch;
    slot_data[9]  = pcm_sw_i;
    slot_vld[12]  = gpio_vld_i;
    slot_data[12] = {gpio_data_i, {(SLOT_W-GPIO_W){1'b0}}};
  end

  assign frame_o[FRAME_W-1] = 1'b1;
  assign frame_o[FRAME_W-TAG_W+TAG_LO_W-1:FRAME_W-TAG_W] =
    cmd_vld_i ? {{(TAG_LO_W-1){1'b0}}, cmd_addr_i[ADDR_W-1]} : '0;

  // invalid slots are zero-stuffed
  for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
    assign frame_o[FRAME_W-1-s] = slot_vld[s];
    assign frame_o[FRAME_W-TAG_W-1-SLOT_W*(s-1) -: SLOT_W] =
      slot_vld[s] ? slot_data[s] : '0;
  end
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_reset_i,
  input  logic [1:0]        chan_mode_i,
  input  logic [PCM_W-1:0]  pcm_left_i,
  input  logic [PCM_W-1:0]  pcm_right_i,
  input  logic [PCM_W-1:0]  pcm_center_i,
  input  logic [PCM_W-1:0]  pcm_rear_left_i,
  input  logic [PCM_W-1:0]  pcm_rear_right_i,
  input  logic [PCM_W-1:0]  pcm_sub_i,
  input  logic [DAC_W-1:0]  modem_dac_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [GPIO_W-1:0] reg_wdata_i,
  output logic              sync_o,
  output logic              sdata_o
);
  localparam int S6_HI  = FRAME_W - TAG_W - 1 - SLOT_W * 5;
  localparam int S9_LO  = FRAME_W - TAG_W - SLOT_W * 9;
  localparam int S10_HI = FRAME_W - TAG_W - 1 - SLOT_W * 9;
  localparam int S11_LO = FRAME_W - TAG_W - SLOT_W * 11;

  logic               frame_start;
  logic               cmd_vld, gpio_vld;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [GPIO_W-1:0]  cmd_data, gpio_data;
  logic [FRAME_W-1:0] frame_vec, shreg_q;
  chmode_e            mode;

  assign mode = chmode_e'(chan_mode_i);

  aclink_bit_timer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk_i, .rst_ni, .frame_start_o(frame_start), .sync_o
  );

  aclink_cmd_tracker #(
    .ADDR_W(ADDR_W), .GPIO_W(GPIO_W), .GPIO_PRI(GPIO_ADDR_PRI), .GPIO_SEC(GPIO_ADDR_SEC)
  ) u_cmd (
    .clk_i, .rst_ni,
    .frame_start_i(frame_start), .link_reset_i,
    .wr_i(reg_wr_i), .wr_addr_i(reg_addr_i), .wr_data_i(reg_wdata_i),
    .cmd_vld_o(cmd_vld), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .gpio_vld_o(gpio_vld), .gpio_data_o(gpio_data)
  );

  aclink_slot_mux #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .PCM_W(PCM_W),
    .DAC_W(DAC_W), .GPIO_W(GPIO_W), .ADDR_W(ADDR_W)
  ) u_mux (
    .mode_i(mode),
    .pcm_l_i(pcm_left_i), .pcm_r_i(pcm_right_i), .pcm_c_i(pcm_center_i),
    .pcm_rl_i(pcm_rear_left_i), .pcm_rr_i(pcm_rear_right_i), .pcm_sw_i(pcm_sub_i),
    .dac_i(modem_dac_i),
    .cmd_vld_i(cmd_vld), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .gpio_vld_i(gpio_vld), .gpio_data_i(gpio_data),
    .frame_o(frame_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          shreg_q <= '0;
    else if (frame_start) shreg_q <= frame_vec;
    else                  shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
  end

  assign sdata_o = shreg_q[FRAME_W-1];

  assert_tag_frame_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |=> shreg_q[FRAME_W-1]);
  assert_two_ch_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && (mode == MODE_2CH || mode == MODE_RSVD))
      |=> (shreg_q[S6_HI:S9_LO] == '0) && (shreg_q[FRAME_W-7:FRAME_W-10] == '0));
  assert_rsvd_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |=> (shreg_q[S10_HI:S11_LO] == '0) && (shreg_q[FRAME_W-11:FRAME_W-12] == '0));
endmodule

// File: tb/aclink_tx_framer_bench.sv
module aclink_tx_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  typedef struct packed {
    logic [1:0]  mode;
    logic [19:0] l, r, c, rl, rr, sw;
    logic [15:0] dac;
    logic        wr;
    logic [7:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 20'h12345, 20'h6789A, 20'hBCDEF, 20'h13579, 20'h2468A, 20'hFEDCB, 16'hC0DE, 1'b0, 8'h00, 16'h0000},
    '{2'b01, 20'hA0001, 20'hB0002, 20'hC0003, 20'hD0004, 20'hE0005, 20'hF0006, 16'h1111, 1'b1, 8'h02, 16'h1234},
    '{2'b10, 20'h0F0F0, 20'hF0F0F, 20'h55555, 20'hAAAAA, 20'h33333, 20'hCCCCC, 16'hFFFF, 1'b1, 8'h54, 16'hA5C3},
    '{2'b11, 20'h11111, 20'h22222, 20'h33333, 20'h44444, 20'h55555, 20'h66666, 16'h8001, 1'b0, 8'h00, 16'h0000},
    '{2'b10, 20'h9ABCD, 20'h01234, 20'hFFFFF, 20'h00001, 20'h80000, 20'h7FFFF, 16'h4321, 1'b1, 8'hD4, 16'h0F0F},
    '{2'b01, 20'h31415, 20'h92653, 20'h58979, 20'h32384, 20'h62643, 20'h38327, 16'h0000, 1'b1, 8'h26, 16'hBEEF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_reset = 1'b0;
  logic [1:0]  chan_mode = '0;
  logic [19:0] pcm_l = '0, pcm_r = '0, pcm_c = '0, pcm_rl = '0, pcm_rr = '0, pcm_sw = '0;
  logic [15:0] dac = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        sync_o, sdata_o;

  int checks = 0, failures = 0, wd = 0;
  bit finished = 0;

  aclink_tx_framer u_aclink_tx_framer (
    .clk_i(clk), .rst_ni(rst_n), .link_reset_i(link_reset), .chan_mode_i(chan_mode),
    .pcm_left_i(pcm_l), .pcm_right_i(pcm_r), .pcm_center_i(pcm_c),
    .pcm_rear_left_i(pcm_rl), .pcm_rear_right_i(pcm_rr), .pcm_sub_i(pcm_sw),
    .modem_dac_i(dac), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .sync_o(sync_o), .sdata_o(sdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // frame capture at the falling edge
  logic [255:0] cap_buf, last_frame;
  int cap_idx = 0, cap_hi = 0, cap_cyc = 0, sync_hi_last = 0, period_last = 0, frames_done = 0;
  bit cap_active = 0, prev_sync = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cap_active = 0; prev_sync = 0; cap_cyc = 0;
    end else begin
      if (sync_o && !prev_sync) begin
        period_last = cap_cyc; cap_cyc = 0; cap_idx = 0; cap_hi = 0; cap_active = 1;
      end
      cap_cyc++;
      if (cap_active) begin
        cap_buf[255-cap_idx] = sdata_o;
        if (sync_o) cap_hi++;
        if (cap_idx == 255) begin
          last_frame = cap_buf; sync_hi_last = cap_hi; cap_active = 0;
          frames_done++;
        end
        cap_idx++;
      end
      prev_sync = sync_o;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL R1 watchdog: act=%0d exp<%0d", wd, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] slot_of(input logic [255:0] f, input int s);
    return f[239-20*(s-1) -: 20];
  endfunction

  function automatic bit is_gpio(input logic [7:0] a);
    return (a == 8'h54) || (a == 8'hD4);
  endfunction

  function automatic string mode_req(input logic [1:0] m);
    return (m == 2'b10) ? "R6" : (m == 2'b01) ? "R5" : "R4";
  endfunction

  // expected frame built from the requirement text
  function automatic logic [255:0] mk_frame(input vec_t v, input logic cv, input logic [7:0] a,
                                            input logic [15:0] d, input logic gv, input logic [15:0] gd);
    logic [19:0] sd [1:12];
    logic [12:1] sv;
    logic [255:0] f;
    logic six, four;
    six  = (v.mode == 2'b10);
    four = six || (v.mode == 2'b01);
    sv = '0;
    for (int s = 1; s <= 12; s++) sd[s] = '0;
    sv[1] = cv;  sd[1]  = cv ? {1'b0, a[6:0], 12'h000} : 20'h0;
    sv[2] = cv;  sd[2]  = cv ? {d, 4'h0} : 20'h0;
    sv[3] = 1;   sd[3]  = v.l;
    sv[4] = 1;   sd[4]  = v.r;
    sv[5] = 1;   sd[5]  = {v.dac, 4'h0};
    sv[6] = six; sd[6]  = six ? v.c : 20'h0;
    sv[7] = four; sd[7] = four ? v.rl : 20'h0;
    sv[8] = four; sd[8] = four ? v.rr : 20'h0;
    sv[9] = six; sd[9]  = six ? v.sw : 20'h0;
    sv[12] = gv; sd[12] = gv ? {gd, 4'h0} : 20'h0;
    f = '0;
    f[255] = 1'b1;
    for (int s = 1; s <= 12; s++) f[255-s] = sv[s];
    f[242:240] = cv ? {2'b00, a[7]} : 3'b000;
    for (int s = 1; s <= 12; s++) f[239-20*(s-1) -: 20] = sd[s];
    return f;
  endfunction

  task automatic chk_frame(input logic [255:0] exp, input logic [1:0] m, input string r12);
    chk("R2", "tag", 32'(last_frame[255:240]), 32'(exp[255:240]));
    for (int s = 1; s <= 2; s++)  chk("R7", $sformatf("slot%0d", s), 32'(slot_of(last_frame, s)), 32'(slot_of(exp, s)));
    for (int s = 3; s <= 5; s++)  chk("R3", $sformatf("slot%0d", s), 32'(slot_of(last_frame, s)), 32'(slot_of(exp, s)));
    for (int s = 6; s <= 9; s++)  chk(mode_req(m), $sformatf("slot%0d", s), 32'(slot_of(last_frame, s)), 32'(slot_of(exp, s)));
    for (int s = 10; s <= 11; s++) chk("R6", $sformatf("slot%0d", s), 32'(slot_of(last_frame, s)), 32'(slot_of(exp, s)));
    chk(r12, "slot12", 32'(slot_of(last_frame, 12)), 32'(slot_of(exp, 12)));
  endtask

  vec_t cur;
  logic gv_m = 0;
  logic [15:0] gd_m = '0;

  task automatic wait_end();
    @(frames_done);
  endtask

  task automatic apply(input vec_t v);
    chan_mode = v.mode; pcm_l = v.l; pcm_r = v.r; pcm_c = v.c;
    pcm_rl = v.rl; pcm_rr = v.rr; pcm_sw = v.sw; dac = v.dac;
  endtask

  task automatic pulse_wr(input logic [7:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic model_cmd(input logic cv, input logic [7:0] a, input logic [15:0] d);
    if (cv && is_gpio(a)) begin gv_m = 1; gd_m = d; end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "sync in reset", 32'(sync_o), 0);
    chk("R1", "sdata in reset", 32'(sdata_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "sync after release", 32'(sync_o), 1);
    wait_end();
    chk_frame(mk_frame('0, 0, 8'h0, 16'h0, 0, 16'h0), 2'b00, "R8");

    // table walk; writes land in the boundary cycle (R7 bypass)
    for (int i = 0; i < NV; i++) begin
      cur = VECS[i];
      apply(cur);
      if (cur.wr) pulse_wr(cur.addr, cur.data);
      wait_end();
      model_cmd(cur.wr, cur.addr, cur.data);
      chk_frame(mk_frame(cur, cur.wr, cur.addr, cur.data, gv_m, gd_m), cur.mode, "R8");
    end
    chk("R1", "sync high bits", 32'(sync_hi_last), 16);
    chk("R1", "frame period", 32'(period_last), 256);

    // R7: mid-frame write waits for the next boundary
    repeat (100) @(negedge clk);
    pulse_wr(8'h54, 16'h7E81);
    wait_end();
    chk_frame(mk_frame(cur, 0, 8'h0, 16'h0, gv_m, gd_m), cur.mode, "R7");
    wait_end();
    model_cmd(1, 8'h54, 16'h7E81);
    chk_frame(mk_frame(cur, 1, 8'h54, 16'h7E81, gv_m, gd_m), cur.mode, "R8");

    // R7: last write before the boundary wins; non-GPIO leaves slot 12
    repeat (50) @(negedge clk);
    pulse_wr(8'h54, 16'h1111);
    repeat (50) @(negedge clk);
    pulse_wr(8'h10, 16'h2222);
    wait_end();
    wait_end();
    chk_frame(mk_frame(cur, 1, 8'h10, 16'h2222, gv_m, gd_m), cur.mode, "R8");

    // R9: link reset leaves current frame, invalidates the next
    repeat (30) @(negedge clk);
    link_reset = 1; @(negedge clk); link_reset = 0;
    wait_end();
    chk_frame(mk_frame(cur, 0, 8'h0, 16'h0, gv_m, gd_m), cur.mode, "R9");
    gv_m = 0;
    wait_end();
    chk_frame(mk_frame(cur, 0, 8'h0, 16'h0, gv_m, gd_m), cur.mode, "R9");

    // R9: write in the same cycle as link reset is dropped
    repeat (20) @(negedge clk);
    link_reset = 1; reg_wr = 1; reg_addr = 8'h54; reg_wdata = 16'h3333;
    @(negedge clk);
    link_reset = 0; reg_wr = 0;
    wait_end();
    wait_end();
    chk_frame(mk_frame(cur, 0, 8'h0, 16'h0, 0, 16'h0), cur.mode, "R9");

    // R10: inputs sampled at the boundary only
    cur.l = 20'hAAAA1; cur.mode = 2'b00;
    apply(cur);
    repeat (40) @(negedge clk);
    cur.l = 20'h5555E; cur.mode = 2'b10;
    apply(cur);
    wait_end();
    chk("R10", "slot3 held", 32'(slot_of(last_frame, 3)), 32'(20'hAAAA1));
    chk("R10", "slot6 held", 32'(slot_of(last_frame, 6)), 0);
    wait_end();
    chk_frame(mk_frame(cur, 0, 8'h0, 16'h0, 0, 16'h0), cur.mode, "R10");

    // R8: async reset clears the GPIO shadow validity
    pulse_wr(8'hD4, 16'h4242);
    wait_end();
    wait_end();
    chk("R8", "slot12 before reset", 32'(slot_of(last_frame, 12)), 32'({16'h4242, 4'h0}));
    repeat (10) @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "sync in mid reset", 32'(sync_o), 0);
    rst_n = 1;
    wait_end();
    chk_frame(mk_frame(cur, 0, 8'h0, 16'h0, 0, 16'h0), cur.mode, "R8");

    finished = 1;
    summary();
    $finish;
  end
endmodule